// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one serial-flash command each time software pulses `start`. A command is built from a fixed opcode byte followed by optional pieces, each with its own enable: address bytes, a mode byte, write bytes and read bytes. The pieces go out in that fixed order. The block drives chip select, a serial clock at half the system clock rate, and a data bus of up to eight lanes. The lane width is chosen per command and applies to every byte of that command.

Configuration inputs are treated as a register image. They are copied when a start is accepted and stay frozen until the command ends, so software may rewrite them while a command runs. Read bytes are gathered into two 32-bit result words. Those words change only when the closing `done` pulse appears. When the bank-transfer enable is set, each read byte is also emitted on a byte stream as soon as it is complete. When the enable is clear, read data reaches only the result words.

Top module: `flash_cmd_seq`

## Requirements
- R1: Every command starts with the 8-bit `cfg_opcode`, sent MSB first. The `cfg_width` code sets the lanes: 0 = one lane (dq[0]), 1 = two lanes (dq[1:0]), 2 = four lanes (dq[3:0]), 3 = eight lanes (dq[7:0]). A byte takes 8/lanes clock beats, and within each beat the highest lane carries the most significant bit.
- R2: Address, mode, write and read phases follow the opcode in that order, and each phase is present only when its enable is set. The address phase sends `cfg_addr_len`+1 bytes (code 0..3 gives 1..4 bytes), taken from the low bytes of `cmd_addr`, most significant of those bytes first.
- R3: With `cfg_mode_en` set, the byte `mode_bits` is sent once, directly after the address bytes.
- R4: With `cfg_wr_en` set, `cfg_wr_cnt`+1 bytes are sent (code 0..7 gives 1..8 bytes). Byte j for j<4 is `wr_lo[8j+7:8j]`, and byte j for j≥4 is `wr_hi[8(j-4)+7:8(j-4)]`.
- R5: With `cfg_rd_en` set, `cfg_rd_cnt`+1 bytes are captured from `dq_in`. The block samples at the end of each high clock half, uses only the active lanes, and assembles each byte MSB first. Read byte j lands in the same byte position of `rd_lo`/`rd_hi` that R4 uses for write byte j, and unread positions become zero. `dq_oe` is zero throughout the read phase.
- R6: `sclk` rests low and each beat lasts two system clocks, low half then high half. `cs_n` falls one clock before the first rising edge and rises one clock after the last falling edge. A command of N beats therefore holds `cs_n` low for 2N+1 clocks.
- R7: `done` is high for exactly one clock, in the clock where `cs_n` returns high. `rd_lo`/`rd_hi` change only in that clock. A command without a read phase leaves them unchanged.
- R8: `busy` is high from the clock after an accepted start until `cs_n` rises. A `start` while busy is ignored, and so is any configuration change made while busy. After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `dq_oe`=0 and both result words are zero.
- R9: With `cfg_bank_en` set, every completed read byte also appears on `bank_data` with a one-clock `bank_valid`, in byte order. With it clear, `bank_valid` stays low.
- R10: In output phases `dq_oe` is the active-lane mask. Inactive lanes, and every lane outside output phases, have `dq_oe`=0 and `dq_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command start request |
| cfg_opcode | input | 8 | Opcode byte |
| cfg_width | input | 2 | Lane width code |
| cfg_addr_en | input | 1 | Address phase enable |
| cfg_addr_len | input | 2 | Address bytes minus one |
| cmd_addr | input | 32 | Command address |
| cfg_mode_en | input | 1 | Mode byte phase enable |
| mode_bits | input | 8 | Mode byte value |
| cfg_wr_en | input | 1 | Write phase enable |
| cfg_wr_cnt | input | 3 | Write bytes minus one |
| wr_lo | input | 32 | Write bytes 0..3 |
| wr_hi | input | 32 | Write bytes 4..7 |
| cfg_rd_en | input | 1 | Read phase enable |
| cfg_rd_cnt | input | 3 | Read bytes minus one |
| cfg_bank_en | input | 1 | Bank-transfer enable for the read byte stream |
| dq_in | input | 8 | Data lanes from the device |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| dq_out | output | 8 | Data lanes to the device |
| dq_oe | output | 8 | Per-lane output enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |
| rd_lo | output | 32 | Read bytes 0..3 |
| rd_hi | output | 32 | Read bytes 4..7 |
| bank_valid | output | 1 | Read byte stream strobe |
| bank_data | output | 8 | Read byte stream data |

## Verification
A wrong phase selection or byte counter shows up at once at the ports. The bus carries the wrong lane bits in the first beat after the fault, and the `cs_n` low time moves away from 2N+1 clocks. A wrong capture shift or byte position is seen only at `done`, as a wrong result word, and earlier on `bank_data` when the bank stream is on. A frozen-configuration fault shows as a bit stream that follows inputs changed in mid-command, or as a second frame after `done`.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int DQ_W      = 8;
  localparam int WORD_W    = 32;
  localparam int MAX_BYTES = 8;
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int CNT_W     = IDX_W + 1;
  localparam int LANE_W    = $clog2(DQ_W) + 1;

  typedef enum logic [2:0] {
    PH_OPC  = 3'd0,
    PH_ADDR = 3'd1,
    PH_MODE = 3'd2,
    PH_WR   = 3'd3,
    PH_RD   = 3'd4,
    PH_END  = 3'd5
  } phase_t;

  typedef struct packed {
    logic [7:0]          opcode;
    logic [1:0]          width;
    logic                addr_en;
    logic [1:0]          addr_len;
    logic [WORD_W-1:0]   addr;
    logic                mode_en;
    logic [7:0]          mode_val;
    logic                wr_en;
    logic [IDX_W-1:0]    wr_cnt;
    logic [2*WORD_W-1:0] wr_data;
    logic                rd_en;
    logic [IDX_W-1:0]    rd_cnt;
    logic                bank_en;
  } cmd_cfg_t;

  // number of active lanes for a width code
  function automatic logic [LANE_W-1:0] lanes_of(logic [1:0] w);
    return LANE_W'(1) << w;
  endfunction

  // beat index of the last beat of a byte
  function automatic logic [IDX_W-1:0] last_beat(logic [1:0] w);
    return IDX_W'((4'd8 >> w) - 4'd1);
  endfunction

  function automatic logic [DQ_W-1:0] lane_mask(logic [1:0] w);
    return DQ_W'((9'd1 << lanes_of(w)) - 9'd1);
  endfunction

  function automatic logic phase_on(phase_t p, cmd_cfg_t c);
    case (p)
      PH_OPC:  return 1'b1;
      PH_ADDR: return c.addr_en;
      PH_MODE: return c.mode_en;
      PH_WR:   return c.wr_en;
      PH_RD:   return c.rd_en;
      default: return 1'b0;
    endcase
  endfunction

  // bytes carried by a phase (1..8)
  function automatic logic [CNT_W-1:0] phase_len(phase_t p, cmd_cfg_t c);
    case (p)
      PH_ADDR: return CNT_W'(c.addr_len) + CNT_W'(1);
      PH_WR:   return CNT_W'(c.wr_cnt) + CNT_W'(1);
      PH_RD:   return CNT_W'(c.rd_cnt) + CNT_W'(1);
      default: return CNT_W'(1);
    endcase
  endfunction

  // smallest enabled phase after p, or PH_END
  function automatic phase_t next_phase(phase_t p, cmd_cfg_t c);
    phase_t n;
    n = PH_END;
    for (int i = 4; i >= 1; i--) begin
      if (i > int'(p) && phase_on(phase_t'(3'(i)), c)) n = phase_t'(3'(i));
    end
    return n;
  endfunction

  // byte to send at position idx of an output phase
  function automatic logic [7:0] byte_of(phase_t p, logic [IDX_W-1:0] idx, cmd_cfg_t c);
    logic [1:0] k;
    k = c.addr_len - 2'(idx);
    case (p)
      PH_OPC:  return c.opcode;
      PH_ADDR: return 8'(c.addr >> {k, 3'b000});
      PH_MODE: return c.mode_val;
      PH_WR:   return 8'(c.wr_data >> {idx, 3'b000});
      default: return 8'h00;
    endcase
  endfunction

  // lane group of byte b sent in a given beat; top lane holds the MSB
  function automatic logic [DQ_W-1:0] lane_slice(logic [7:0] b, logic [IDX_W-1:0] beat,
                                                 logic [1:0] w);
    logic [LANE_W-1:0] l;
    logic [3:0]        sh;
    l  = lanes_of(w);
    sh = 4'd8 - 4'(l * (LANE_W'(beat) + LANE_W'(1)));
    return (b >> sh) & lane_mask(w);
  endfunction
endpackage

// File: rtl/sfc_phase_ctrl.sv
module sfc_phase_ctrl
  import sfc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  cmd_cfg_t         cfg,
  output phase_t           phase,
  output logic [IDX_W-1:0] byte_idx,
  output logic [IDX_W-1:0] beat_idx,
  output logic             byte_last,
  output logic             cmd_last
);
  logic   phase_done;
  phase_t phase_nx;

  assign byte_last  = (beat_idx == last_beat(cfg.width));
  assign phase_done = ({1'b0, byte_idx} == phase_len(phase, cfg) - CNT_W'(1));
  assign phase_nx   = next_phase(phase, cfg);
  assign cmd_last   = byte_last && phase_done && (phase_nx == PH_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_END;
      byte_idx <= '0;
      beat_idx <= '0;
    end else if (load) begin
      phase    <= PH_OPC;
      byte_idx <= '0;
      beat_idx <= '0;
    end else if (step) begin
      if (byte_last) begin
        beat_idx <= '0;
        if (phase_done) begin
          phase    <= phase_nx;
          byte_idx <= '0;
        end else begin
          byte_idx <= byte_idx + IDX_W'(1);
        end
      end else begin
        beat_idx <= beat_idx + IDX_W'(1);
      end
    end
  end

  // R2: phases only move forward, except the restart at OPC
  a_r2_forward_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != $past(phase)) |-> (phase > $past(phase) || phase == PH_OPC));

  // R2: a disabled optional phase is never entered
  a_r2_skip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_END && phase != PH_OPC) |-> phase_on(phase, cfg));
endmodule

// File: rtl/sfc_serializer.sv
module sfc_serializer
  import sfc_pkg::*;
(
  input  logic             drive_en,
  input  cmd_cfg_t         cfg,
  input  phase_t           phase,
  input  logic [IDX_W-1:0] byte_idx,
  input  logic [IDX_W-1:0] beat_idx,
  output logic [DQ_W-1:0]  dq_out,
  output logic [DQ_W-1:0]  dq_oe
);
  logic [7:0]      cur_byte;
  logic [DQ_W-1:0] bits;
  logic [DQ_W-1:0] mask;

  assign cur_byte = byte_of(phase, byte_idx, cfg);
  assign bits     = lane_slice(cur_byte, beat_idx, cfg.width);
  assign mask     = lane_mask(cfg.width);

  for (genvar i = 0; i < DQ_W; i++) begin : g_lane
    assign dq_oe[i]  = drive_en && mask[i];
    assign dq_out[i] = dq_oe[i] && bits[i];
  end
endmodule

// File: rtl/sfc_capture.sv
module sfc_capture
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              byte_last,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [1:0]        width,
  input  logic [DQ_W-1:0]   dq_in,
  input  logic              bank_en,
  input  logic              commit,
  output logic [WORD_W-1:0] rd_lo,
  output logic [WORD_W-1:0] rd_hi,
  output logic              bank_valid,
  output logic [7:0]        bank_data
);
  logic [7:0]          shift_q;
  logic [7:0]          shift_nx;
  logic [2*WORD_W-1:0] acc_q;

  assign shift_nx = 8'(shift_q << lanes_of(width)) | 8'(dq_in & lane_mask(width));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q    <= '0;
      acc_q      <= '0;
      rd_lo      <= '0;
      rd_hi      <= '0;
      bank_valid <= 1'b0;
      bank_data  <= '0;
    end else begin
      bank_valid <= 1'b0;
      if (clear) begin
        shift_q <= '0;
        acc_q   <= '0;
      end else if (sample) begin
        if (byte_last) begin
          acc_q[{byte_idx, 3'b000} +: 8] <= shift_nx;
          shift_q    <= '0;
          bank_valid <= bank_en;
          bank_data  <= shift_nx;
        end else begin
          shift_q <= shift_nx;
        end
      end
      if (commit) begin
        rd_lo <= acc_q[WORD_W-1:0];
        rd_hi <= acc_q[2*WORD_W-1:WORD_W];
      end
    end
  end

  // R9: a completed byte needs at least two clocks, so strobes never touch
  a_r9_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bank_valid |=> !bank_valid);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import sfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        cfg_opcode,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_addr_en,
  input  logic [1:0]        cfg_addr_len,
  input  logic [WORD_W-1:0] cmd_addr,
  input  logic              cfg_mode_en,
  input  logic [7:0]        mode_bits,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_cnt,
  input  logic [WORD_W-1:0] wr_lo,
  input  logic [WORD_W-1:0] wr_hi,
  input  logic              cfg_rd_en,
  input  logic [IDX_W-1:0]  cfg_rd_cnt,
  input  logic              cfg_bank_en,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              sclk,
  output logic              cs_n,
  output logic [DQ_W-1:0]   dq_out,
  output logic [DQ_W-1:0]   dq_oe,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_lo,
  output logic [WORD_W-1:0] rd_hi,
  output logic              bank_valid,
  output logic [7:0]        bank_data
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD} seq_state_t;

  seq_state_t       state;
  logic             high_half;
  cmd_cfg_t         cfg_q;
  cmd_cfg_t         cfg_in;
  phase_t           phase;
  logic [IDX_W-1:0] byte_idx;
  logic [IDX_W-1:0] beat_idx;
  logic             byte_last;
  logic             cmd_last;

  // named internal events
  logic accept;
  logic beat_end;
  logic rd_phase;
  logic drive_en;
  logic rd_sample;
  logic commit;

  assign cfg_in = '{opcode: cfg_opcode, width: cfg_width, addr_en: cfg_addr_en,
                    addr_len: cfg_addr_len, addr: cmd_addr, mode_en: cfg_mode_en,
                    mode_val: mode_bits, wr_en: cfg_wr_en, wr_cnt: cfg_wr_cnt,
                    wr_data: {wr_hi, wr_lo}, rd_en: cfg_rd_en, rd_cnt: cfg_rd_cnt,
                    bank_en: cfg_bank_en};

  assign accept    = start && (state == S_IDLE);
  assign beat_end  = (state == S_SHIFT) && high_half;
  assign rd_phase  = (state != S_IDLE) && (phase == PH_RD);
  assign drive_en  = (state == S_SETUP || state == S_SHIFT) && (phase != PH_RD);
  assign rd_sample = beat_end && (phase == PH_RD);
  assign commit    = (state == S_HOLD) && cfg_q.rd_en;

  assign busy = (state != S_IDLE);
  assign cs_n = (state == S_IDLE);
  assign sclk = beat_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      high_half <= 1'b0;
      cfg_q     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            cfg_q <= cfg_in;
            state <= S_SETUP;
          end
        end
        S_SETUP: begin
          state     <= S_SHIFT;
          high_half <= 1'b1;
        end
        S_SHIFT: begin
          if (high_half) begin
            high_half <= 1'b0;
            if (cmd_last) state <= S_HOLD;
          end else begin
            high_half <= 1'b1;
          end
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  sfc_phase_ctrl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (beat_end),
    .cfg      (cfg_q),
    .phase    (phase),
    .byte_idx (byte_idx),
    .beat_idx (beat_idx),
    .byte_last(byte_last),
    .cmd_last (cmd_last)
  );

  sfc_serializer u_ser (
    .drive_en(drive_en),
    .cfg     (cfg_q),
    .phase   (phase),
    .byte_idx(byte_idx),
    .beat_idx(beat_idx),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe)
  );

  sfc_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .sample    (rd_sample),
    .byte_last (byte_last),
    .byte_idx  (byte_idx),
    .width     (cfg_q.width),
    .dq_in     (dq_in),
    .bank_en   (cfg_q.bank_en),
    .commit    (commit),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .bank_valid(bank_valid),
    .bank_data (bank_data)
  );

  // R6: bus lines rest while no command runs
  a_r6_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk && dq_oe == '0));

  // R6: the serial clock only pulses inside a frame
  a_r6_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  // R7: done comes in the clock where chip select returns high
  a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));

  // R7: done is a single-clock pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: result words move only with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rd_lo) && $stable(rd_hi)));

  // R5: nothing is driven while the device answers
  a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> (dq_oe == '0));

  // R8: the latched command cannot change while it runs
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

  // R10: lanes without an output enable stay low
  a_r10_quiet_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out & ~dq_oe) == '0);
endmodule

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cfg_opcode = '0;
  logic [1:0]  cfg_width = '0;
  logic        cfg_addr_en = 1'b0;
  logic [1:0]  cfg_addr_len = '0;
  logic [31:0] cmd_addr = '0;
  logic        cfg_mode_en = 1'b0;
  logic [7:0]  mode_bits = '0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_cnt = '0;
  logic [31:0] wr_lo = '0;
  logic [31:0] wr_hi = '0;
  logic        cfg_rd_en = 1'b0;
  logic [2:0]  cfg_rd_cnt = '0;
  logic        cfg_bank_en = 1'b0;
  logic [7:0]  dq_in = '0;
  logic        sclk, cs_n, busy, done, bank_valid;
  logic [7:0]  dq_out, dq_oe, bank_data;
  logic [31:0] rd_lo, rd_hi;

  always #2.5 clk = ~clk;

  flash_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_opcode(cfg_opcode),
    .cfg_width(cfg_width), .cfg_addr_en(cfg_addr_en), .cfg_addr_len(cfg_addr_len),
    .cmd_addr(cmd_addr), .cfg_mode_en(cfg_mode_en), .mode_bits(mode_bits),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_cnt(cfg_wr_cnt), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .cfg_rd_en(cfg_rd_en), .cfg_rd_cnt(cfg_rd_cnt), .cfg_bank_en(cfg_bank_en),
    .dq_in(dq_in), .sclk(sclk), .cs_n(cs_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .busy(busy), .done(done), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .bank_valid(bank_valid), .bank_data(bank_data)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor and device model, all at the falling system clock edge
  int         cs_cycles, first_rise, last_rise, nbeats, nbank, done_cnt, pseed;
  logic [7:0] rec_dq [256];
  logic [7:0] rec_oe [256];
  logic [7:0] bank_rec [16];

  function automatic logic [7:0] pat(input int g);
    return 8'((g * 53 + 29 + pseed * 7) & 255);
  endfunction

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (bank_valid && nbank < 16) begin
      bank_rec[nbank] = bank_data;
      nbank++;
    end
    if (!cs_n) begin
      cs_cycles++;
      if (sclk) begin
        if (nbeats < 256) begin
          rec_dq[nbeats] = dq_out;
          rec_oe[nbeats] = dq_oe;
        end
        if (first_rise < 0) first_rise = cs_cycles;
        last_rise = cs_cycles;
        nbeats++;
      end else begin
        dq_in = pat(nbeats);
      end
    end
  end

  logic [31:0] exp_lo = '0;
  logic [31:0] exp_hi = '0;

  task automatic run_cmd(input logic [7:0] op, input logic [1:0] w,
                         input bit ae, input logic [1:0] al, input logic [31:0] ad,
                         input bit me, input logic [7:0] mv,
                         input bit we, input logic [2:0] wc,
                         input logic [31:0] wl, input logic [31:0] wh,
                         input bit re, input logic [2:0] rc, input bit be,
                         input bit intr, input int seed);
    logic [7:0] outb [24];
    int         cat [24];
    int         nb, lanes, bpb, nbt, err [5], quiet, cyc, rb;
    logic [7:0] rbyte;
    logic [7:0] ebytes [8];
    logic [7:0] mask;
    bit         seen;

    @(negedge clk);
    cs_cycles = 0; first_rise = -1; last_rise = -1; nbeats = 0; nbank = 0;
    done_cnt = 0; pseed = seed;
    cfg_opcode = op; cfg_width = w; cfg_addr_en = ae; cfg_addr_len = al;
    cmd_addr = ad; cfg_mode_en = me; mode_bits = mv; cfg_wr_en = we;
    cfg_wr_cnt = wc; wr_lo = wl; wr_hi = wh; cfg_rd_en = re; cfg_rd_cnt = rc;
    cfg_bank_en = be;
    start = 1'b1;
    cyc = 0;
    seen = 0;
    while (!seen && cyc < 2000) begin
      @(negedge clk);
      start = 1'b0;
      if (cyc == 0) check(busy === 1'b1, "R8", "busy after start", busy, 1);
      if (intr && cyc == 6) begin
        cfg_opcode = ~op; cmd_addr = ~ad; cfg_width = ~w; cfg_rd_en = ~re;
        start = 1'b1;
      end
      if (done) seen = 1;
      cyc++;
    end
    check(seen, "R7", "done seen", seen, 1);
    repeat (3) @(negedge clk);
    check(done_cnt == 1 && cs_n && !busy, "R8", "single done, idle after, no second frame",
          done_cnt, 1);

    // expected output bytes, tagged by phase
    lanes = 1 << w;
    bpb = 8 / lanes;
    mask = 8'((1 << lanes) - 1);
    nb = 0;
    outb[nb] = op; cat[nb] = 0; nb++;
    if (ae) for (int j = 0; j <= int'(al); j++) begin
      outb[nb] = 8'(ad >> (8 * (int'(al) - j))); cat[nb] = 1; nb++;
    end
    if (me) begin outb[nb] = mv; cat[nb] = 2; nb++; end
    if (we) for (int j = 0; j <= int'(wc); j++) begin
      outb[nb] = (j < 4) ? 8'(wl >> (8 * j)) : 8'(wh >> (8 * (j - 4)));
      cat[nb] = 3; nb++;
    end
    rb = nb;
    if (re) for (int j = 0; j <= int'(rc); j++) begin
      outb[nb] = 8'h00; cat[nb] = 4; nb++;
    end
    nbt = nb * bpb;

    check(cs_cycles == 2 * nbt + 1 && first_rise == 2 && last_rise == 2 * nbt,
          "R6", "frame length in clocks", cs_cycles, 2 * nbt + 1);
    check(nbeats == nbt, "R2", "beat count", nbeats, nbt);

    for (int k = 0; k < 5; k++) err[k] = 0;
    quiet = 0;
    for (int g = 0; g < nbt && g < nbeats; g++) begin
      logic [7:0] edq;
      logic [7:0] eoe;
      int         bi, bt;
      bi = g / bpb;
      bt = g % bpb;
      edq = 8'h00;
      eoe = 8'h00;
      if (cat[bi] < 4) begin
        eoe = mask;
        for (int i = 0; i < lanes; i++) edq[i] = outb[bi][8 - lanes * (bt + 1) + i];
      end
      if (rec_dq[g] !== edq || rec_oe[g] !== eoe) err[cat[bi]]++;
      if ((rec_dq[g] & ~rec_oe[g]) != 8'h00) quiet++;
    end
    check(err[0] == 0, "R1", "opcode beats", err[0], 0);
    if (ae) check(err[1] == 0, "R2", "address beats", err[1], 0);
    if (me) check(err[2] == 0, "R3", "mode beats", err[2], 0);
    if (we) check(err[3] == 0, "R4", "write beats", err[3], 0);
    if (re) check(err[4] == 0, "R5", "read phase undriven", err[4], 0);
    check(quiet == 0, "R10", "inactive lanes low", quiet, 0);

    if (re) begin
      exp_lo = '0;
      exp_hi = '0;
      for (int j = 0; j <= int'(rc); j++) begin
        rbyte = 8'h00;
        for (int b = 0; b < bpb; b++)
          rbyte = 8'((rbyte << lanes) | (pat((rb + j) * bpb + b) & mask));
        ebytes[j] = rbyte;
        if (j < 4) exp_lo[8 * j +: 8] = rbyte;
        else exp_hi[8 * (j - 4) +: 8] = rbyte;
      end
      check(rd_lo === exp_lo, "R5", "rd_lo", rd_lo, exp_lo);
      check(rd_hi === exp_hi, "R5", "rd_hi", rd_hi, exp_hi);
      if (be) begin
        int berr;
        berr = 0;
        for (int j = 0; j <= int'(rc); j++) if (bank_rec[j] !== ebytes[j]) berr++;
        check(nbank == int'(rc) + 1 && berr == 0, "R9", "bank byte stream", nbank,
              int'(rc) + 1);
      end else begin
        check(nbank == 0, "R9", "no bank strobes when disabled", nbank, 0);
      end
    end else begin
      check(rd_lo === exp_lo && rd_hi === exp_hi, "R7", "results kept without read",
            {rd_hi, rd_lo}, {exp_hi, exp_lo});
      check(nbank == 0, "R9", "no strobes without read", nbank, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0 &&
          dq_oe === 8'h00 && rd_lo === '0 && rd_hi === '0,
          "R8", "reset state", {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // opcode-only command, single lane
    run_cmd(8'h06, 2'd0, 0, 2'd0, 32'h0, 0, 8'h0, 0, 3'd0, 32'h0, 32'h0,
            0, 3'd0, 0, 0, 1);
    // full read of eight bytes on eight lanes with the byte stream
    run_cmd(8'hEB, 2'd3, 1, 2'd3, 32'h89AB_CDEF, 1, 8'hA5, 0, 3'd0, 32'h0, 32'h0,
            1, 3'd7, 1, 0, 2);
    // start and input changes while busy are ignored
    run_cmd(8'h9F, 2'd1, 1, 2'd2, 32'h0012_3456, 0, 8'h0, 1, 3'd2, 32'h1122_3344,
            32'h5566_7788, 1, 3'd3, 0, 1, 3);

    // sweep every width and every combination of optional phases
    for (int w = 0; w < 4; w++) begin
      for (int e = 0; e < 16; e++) begin
        run_cmd(8'(8'h31 + e * 4 + w), 2'(w), e[0], 2'((e + w) % 4),
                32'hA1B2_C3D4 ^ 32'(e << 12) ^ 32'(w << 3),
                e[1], 8'(8'h5A ^ e), e[2], 3'((e * 3 + w) % 8),
                32'hDEAD_BEEF ^ 32'(e), 32'h0BAD_F00D ^ 32'(w << 20),
                e[3], 3'((e * 5 + w * 3) % 8), 1'((e + w) % 2), 0, 10 + e * 4 + w);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule